// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Sequencer

This block is the fault-handling state machine of a multiphase PWM converter. It watches an averaged-current overcurrent comparator flag. When the flag is seen while the converter is switching, every phase's PWM output enable is dropped, so the phase outputs float and the gate drivers turn off both the high-side and the low-side switch of each phase.

After a trip, the block holds the outputs off for a fixed blanking interval counted in phase-clock cycles (default 2048). It then asks the ramp logic for a soft-start. A ramp that finishes without a new trip returns the converter to normal regulation. A trip before the ramp finishes sends the block back into the blanking interval. This retry loop repeats with no limit for as long as enable stays high.

Dropping enable parks the block in an idle state with all outputs off. A saturating counter records how many trips have occurred.

Top module: `ocp_hiccup_seq`

## Requirements
- R1: After reset the block is idle (`state_o` = 0), `pwm_oe` is all zeros, `ss_req` is 0 and `fault_cnt` is 0.
- R2: `state_o` codes are idle = 0, normal = 1, fault-wait = 2 and soft-start = 3. `pwm_oe` is all ones in normal and soft-start and all zeros in idle and fault-wait. `ss_req` is 1 only in soft-start.
- R3: In idle with `en` high, the block enters soft-start on the next rising edge.
- R4: In soft-start, with `ss_done` high and no synchronized trip, the block enters normal on the next rising edge.
- R5: `oc_raw` passes through two synchronizer flops. A trip in normal or soft-start shows on the third rising edge after `oc_raw` rises. On that edge the block enters fault-wait and `fault_cnt` increases by one.
- R6: Fault-wait lasts exactly `WAIT_CYCLES` cycles and then gives way to soft-start. `oc_raw` and `ss_done` have no effect during fault-wait.
- R7: In soft-start, a synchronized trip takes priority over `ss_done` and sends the block back to fault-wait. With the trip held, the wait and retry repeat without end.
- R8: With `en` low, the block is idle on the next rising edge from any state.
- R9: `fault_cnt` saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Controller enable |
| oc_raw | input | 1 | Overcurrent comparator flag, asynchronous |
| ss_done | input | 1 | Soft-start ramp finished |
| pwm_oe | output | PHASES | Per-phase PWM output enable; 0 floats that phase |
| ss_req | output | 1 | Soft-start request |
| state_o | output | 2 | Sequencer state code |
| fault_cnt | output | 8 | Saturating trip count |

## Verification
Changes on `en` and `ss_done` are due one rising edge after they are applied. Trips on `oc_raw` are due on the third edge, and the end of fault-wait is due exactly `WAIT_CYCLES` edges after it is entered. The bench drives inputs on falling edges. Each vector carries its own count of edges to advance before the outputs are sampled, on a falling edge. These counts are worked out from those latencies: for example, 2 edges before the trip to show that the trip has not yet arrived, then 1 more edge, and 15 and then 16 edges to bracket the end of a 16-cycle wait.

// File: rtl/ocp_hiccup_seq.sv
module ocp_hiccup_seq #(
  parameter int PHASES      = 4,
  parameter int WAIT_CYCLES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              oc_raw,
  input  logic              ss_done,
  output logic [PHASES-1:0] pwm_oe,
  output logic              ss_req,
  output logic [1:0]        state_o,
  output logic [7:0]        fault_cnt
);
  localparam int CW = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_RUN  = 2'd1;
  localparam logic [1:0] S_WAIT = 2'd2;
  localparam logic [1:0] S_SOFT = 2'd3;

  logic          oc_m, oc_q;
  logic [1:0]    state;
  logic [CW-1:0] cnt;
  logic          trip;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {oc_q, oc_m} <= 2'b00;
    else        {oc_q, oc_m} <= {oc_m, oc_raw};

  assign trip = en && oc_q && (state == S_RUN || state == S_SOFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (!en) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (trip) begin
      state <= S_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: state <= S_SOFT;
        S_SOFT: if (ss_done) state <= S_RUN;
        S_WAIT:
          if (cnt == LAST) begin
            state <= S_SOFT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: state <= state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       fault_cnt <= '0;
    else if (trip && fault_cnt != '1) fault_cnt <= fault_cnt + 1'b1;

  assign pwm_oe  = {PHASES{state == S_RUN || state == S_SOFT}};
  assign ss_req  = (state == S_SOFT);
  assign state_o = state;
endmodule

// File: rtl/ocp_hiccup_seq_chk.sv
module ocp_hiccup_seq_chk #(
  parameter int PHASES      = 4,
  parameter int WAIT_CYCLES = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              oc_q,
  input logic              ss_done,
  input logic [1:0]        state,
  input logic [PHASES-1:0] pwm_oe,
  input logic              ss_req,
  input logic [7:0]        fault_cnt
);
  int wc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            wc <= 0;
    else if (state == 2'd2) wc <= wc + 1;
    else                   wc <= 0;

  // R2
  wait_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd2 |-> pwm_oe == '0 && !ss_req);

  // R4
  soft_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !oc_q && state == 2'd3 && ss_done) |=> state == 2'd1);

  // R5
  run_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oc_q && state == 2'd1) |=> state == 2'd2);

  // R6
  wait_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == 2'd2 && wc == WAIT_CYCLES - 1) |=> state == 2'd3);

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == 2'd2 && wc < WAIT_CYCLES - 1) |=> state == 2'd2);

  // R7
  soft_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oc_q && state == 2'd3) |=> state == 2'd2);

  // R8
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state == 2'd0);

  // R9
  fault_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cnt == 8'hFF |=> fault_cnt == 8'hFF);
endmodule

bind ocp_hiccup_seq ocp_hiccup_seq_chk #(.PHASES(PHASES), .WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .oc_q(oc_q), .ss_done(ss_done),
  .state(state_o), .pwm_oe(pwm_oe), .ss_req(ss_req), .fault_cnt(fault_cnt)
);

// File: tb/ocp_hiccup_seq_bench.sv
module ocp_hiccup_seq_bench;
  localparam int PH = 4;
  localparam int W  = 16;

  logic clk = 0, rst_n = 0, en = 0, oc_raw = 0, ss_done = 0;
  logic [PH-1:0] pwm_oe;
  logic ss_req;
  logic [1:0] state_o;
  logic [7:0] fault_cnt;
  int checks = 0, failures = 0;

  ocp_hiccup_seq #(.PHASES(PH), .WAIT_CYCLES(W)) u_ocp_hiccup_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .oc_raw(oc_raw), .ss_done(ss_done),
    .pwm_oe(pwm_oe), .ss_req(ss_req), .state_o(state_o), .fault_cnt(fault_cnt));

  always #4 clk = ~clk;

  // {en, oc, done, edges[7:0], state[1:0], faults[7:0]}
  localparam logic [20:0] VEC [12] = '{
    {1'b1, 1'b0, 1'b0, 8'd1,  2'd3, 8'd0},  // R3 idle -> soft
    {1'b1, 1'b0, 1'b1, 8'd1,  2'd1, 8'd0},  // R4 soft -> run
    {1'b1, 1'b1, 1'b0, 8'd2,  2'd1, 8'd0},  // R5 trip still in synchronizer
    {1'b1, 1'b1, 1'b0, 8'd1,  2'd2, 8'd1},  // R5 third edge -> wait
    {1'b1, 1'b0, 1'b0, 8'd15, 2'd2, 8'd1},  // R6 still waiting
    {1'b1, 1'b0, 1'b0, 8'd1,  2'd3, 8'd1},  // R6 wait ends -> soft
    {1'b1, 1'b1, 1'b0, 8'd3,  2'd2, 8'd2},  // R7 trip during soft
    {1'b1, 1'b1, 1'b0, 8'd16, 2'd3, 8'd2},  // R6 oc ignored in wait
    {1'b1, 1'b1, 1'b0, 8'd1,  2'd2, 8'd3},  // R7 retry trips again
    {1'b1, 1'b0, 1'b1, 8'd16, 2'd3, 8'd3},  // R6 done ignored in wait
    {1'b1, 1'b0, 1'b1, 8'd1,  2'd1, 8'd3},  // R4 recovered
    {1'b0, 1'b0, 1'b0, 8'd1,  2'd0, 8'd3}   // R8 disable -> idle
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [1:0] st, input logic [7:0] f, input string tag);
    logic [PH-1:0] eoe;
    eoe = (st == 2'd1 || st == 2'd3) ? '1 : '0;
    checks++;
    if (state_o !== st || pwm_oe !== eoe || ss_req !== (st == 2'd3) || fault_cnt !== f) begin
      failures++;
      $display("FAIL %s: state=%0d oe=%b req=%b faults=%0d expected state=%0d oe=%b req=%b faults=%0d",
               tag, state_o, pwm_oe, ss_req, fault_cnt, st, eoe, st == 2'd3, f);
    end
  endtask

  initial begin
    tick(2);
    check(2'd0, 8'd0, "R1 reset");
    rst_n = 1;
    tick(1);
    check(2'd0, 8'd0, "R1 idle held");
    for (int i = 0; i < 12; i++) begin
      {en, oc_raw, ss_done} = VEC[i][20:18];
      tick(int'(VEC[i][17:10]));
      check(VEC[i][9:8], VEC[i][7:0], $sformatf("R2 vector %0d", i));
    end

    // R9: hold the trip so the loop retries endlessly
    en = 1; oc_raw = 1; ss_done = 1;
    tick(300 * (W + 1));
    check(state_o == 2'd3 ? 2'd3 : 2'd2, 8'd255, "R9 saturation");
    for (int k = 0; k < 2 * W && state_o != 2'd3; k++) tick(1);
    check(2'd3, 8'd255, "R7 soft reached");
    tick(1);
    check(2'd2, 8'd255, "R7 trip beats done");
    tick(5);
    en = 0;
    tick(1);
    check(2'd0, 8'd255, "R8 disable mid-wait");

    rst_n = 0;
    tick(1);
    check(2'd0, 8'd0, "R1 reset again");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule